// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps the programming state for a small set of DMA channels and judges the transfer requests that devices raise against that state. Each channel holds three 32-bit registers: a mode word, a remaining byte count and a start address. Software programs them through a word-wide register port that has combinational read data and single-cycle writes.

A device asks for a transfer by giving a channel number, a length in bytes and a direction. One clock later the block answers. The answer is either a grant, which carries the length to move (clamped to what the channel still has) and the programmed start address, or an error. On an error the block raises the channel's memory-error flag and latches a per-channel bit in a non-maskable interrupt source word. The data movement and any address translation belong to other blocks. The start address is never advanced, so software re-arms it between transfers.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register, the interrupt source word and `rsp_valid` read as zero.
- R2: Channel n's registers sit at offset CH_BASE + 32*n + 8*s, with CH_BASE = 0x100 by default. Slot s=1 is the mode word, s=2 the count and s=3 the address. A write stores all 32 bits and reads back unchanged. Slot 0 reads zero and ignores writes.
- R3: The interrupt source word at offset 0x200 holds bit n for channel n and is read-only: writes to it have no effect. Any offset outside the channel window and that word reads zero (for example 0x000 and 0x180).
- R4: Each request held for one cycle on `req_valid` produces exactly one response with `rsp_valid` high in the following cycle. Back-to-back requests are answered in back-to-back cycles.
- R5: A request on a channel whose mode bit 0 (enable) is 0, or whose `req_m2d` differs from mode bit 1 (1 = memory to device), is refused. `rsp_err` is 1, `rsp_len` and `rsp_addr` are 0, mode bit 9 (memory error) is set, interrupt source bit n is set, and the count is unchanged.
- R6: An accepted request gets `rsp_err`=0 and `rsp_len` = min(`req_len`, count), which may be zero. The count drops by `rsp_len` and mode bit 8 (terminal count) is set.
- R7: Every request first clears mode bits 8, 9 and 10 (address error), then sets only the flag its outcome calls for. All other mode bits are kept.
- R8: `rsp_addr` of an accepted request equals the channel's address register, and that register is not changed by the transfer.
- R9: Interrupt source bits stay set across later requests, accepted or refused, until reset.
- R10: When a register write and a request hit the same channel in the same cycle, a write to its mode or count is discarded and the request's update applies. A write to its address takes effect, and the response still reports the address held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W (10) | Register byte offset |
| csr_wdata | input | DATA_W (32) | Register write data |
| csr_rdata | output | DATA_W (32) | Register read data, combinational from `csr_addr` |
| req_valid | input | 1 | Device transfer request, one cycle per request |
| req_ch | input | log2(NUM_CH) (2) | Requested channel |
| req_len | input | LEN_W (16) | Requested length in bytes |
| req_m2d | input | 1 | Request direction, 1 = memory to device |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request refused |
| rsp_len | output | LEN_W (16) | Granted length |
| rsp_addr | output | DATA_W (32) | Start address of the grant |

## Verification
A response is due on the clock edge after the request is captured. The scoreboard therefore stamps every expected item with the cycle number of that edge, and the monitor compares the stamp when it pops the item at the following falling edge. Register updates made by a request are visible to reads from that same falling edge onward. Reads are combinational, so each read check drives the offset on a falling edge and samples a short delay later, never near a rising edge. The combined write-and-request cycles for R10 are driven on one falling edge, so both land on the same rising edge.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
   // mode word bit positions
   localparam int MODE_EN   = 0;
   localparam int MODE_M2D  = 1;
   localparam int MODE_TC   = 8;
   localparam int MODE_MERR = 9;
   localparam int MODE_AERR = 10;
   // register slots inside a channel's 32-byte window
   localparam int SLOT_MODE = 1;
   localparam int SLOT_CNT  = 2;
   localparam int SLOT_ADDR = 3;
   localparam int STRIDE_LOG2 = 5;
endpackage

// File: rtl/dmacc_chan.sv
module dmacc_chan
   import dmacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic              wr_cnt,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              upd,
   input  logic              upd_err,
   input  logic [LEN_W-1:0]  upd_len,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         cnt_q  <= '0;
         addr_q <= '0;
      end else begin
         if (upd) begin
            // request update owns mode and count this cycle
            mode_q[MODE_TC]   <= !upd_err;
            mode_q[MODE_MERR] <= upd_err;
            mode_q[MODE_AERR] <= 1'b0;
            if (!upd_err) cnt_q <= cnt_q - DATA_W'(upd_len);
         end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_cnt)  cnt_q  <= wdata;
         end
         if (wr_addr) addr_q <= wdata;
      end
   end
endmodule

// File: rtl/dmacc_eval.sv
module dmacc_eval
   import dmacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic [DATA_W-1:0] mode,
   input  logic [DATA_W-1:0] cnt,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_m2d,
   output logic              err,
   output logic [LEN_W-1:0]  gnt_len
);
   logic short;
   always_comb begin
      err     = !mode[MODE_EN] || (req_m2d != mode[MODE_M2D]);
      short   = cnt < DATA_W'(req_len);
      gnt_len = short ? cnt[LEN_W-1:0] : req_len;
   end
endmodule

// File: rtl/dmacc_rdmux.sv
module dmacc_rdmux
   import dmacc_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                           in_win,
   input  logic [CH_W-1:0]                ch,
   input  logic [1:0]                     slot,
   input  logic                           nmi_hit,
   input  logic [NUM_CH-1:0]              nmi,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  mode_all,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_all,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  addr_all,
   output logic [DATA_W-1:0]              rdata
);
   logic [DATA_W-1:0] nmi_word;

   generate
      if (NUM_CH == DATA_W) begin : g_nmi_full
         assign nmi_word = nmi;
      end else begin : g_nmi_pad
         assign nmi_word = {{(DATA_W-NUM_CH){1'b0}}, nmi};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (in_win) begin
         case (slot)
            2'(SLOT_MODE): rdata = mode_all[ch];
            2'(SLOT_CNT):  rdata = cnt_all[ch];
            2'(SLOT_ADDR): rdata = addr_all[ch];
            default:       rdata = '0;
         endcase
      end else if (nmi_hit) begin
         rdata = nmi_word;
      end
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dmacc_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   parameter int ADDR_W = 10,
   parameter logic [ADDR_W-1:0] CH_BASE = 'h100,
   parameter logic [ADDR_W-1:0] NMI_OFF = 'h200,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_ch,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_m2d,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [DATA_W-1:0] rsp_addr
);
   localparam int WIN_BYTES = NUM_CH << STRIDE_LOG2;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
         $error("NUM_CH must be a power of two, at least 2");
      end
      if (NUM_CH > DATA_W) begin : g_bad_nmi
         $error("NUM_CH must not exceed DATA_W");
      end
      if (DATA_W < MODE_AERR + 1 || LEN_W > DATA_W || LEN_W < 1) begin : g_bad_w
         $error("DATA_W must hold the mode flags and LEN_W must fit in DATA_W");
      end
      if ((int'(CH_BASE) % WIN_BYTES) != 0 ||
          int'(CH_BASE) + WIN_BYTES > (1 << ADDR_W)) begin : g_bad_base
         $error("CH_BASE must be aligned to the channel window and fit in ADDR_W");
      end
      if (int'(NMI_OFF) >= int'(CH_BASE) &&
          int'(NMI_OFF) < int'(CH_BASE) + WIN_BYTES) begin : g_bad_nmi_off
         $error("NMI_OFF must lie outside the channel window");
      end
   endgenerate

   // register-port decode
   logic              in_win;
   logic              nmi_hit;
   logic [CH_W-1:0]   csr_ch;
   logic [1:0]        csr_slot;

   always_comb begin
      in_win   = (csr_addr >= CH_BASE) &&
                 ({1'b0, csr_addr} < ({1'b0, CH_BASE} + (ADDR_W+1)'(WIN_BYTES)));
      nmi_hit  = csr_addr[ADDR_W-1:2] == NMI_OFF[ADDR_W-1:2];
      csr_ch   = csr_addr[STRIDE_LOG2 +: CH_W];
      csr_slot = csr_addr[4:3];
   end

   logic [NUM_CH-1:0][DATA_W-1:0] mode_all;
   logic [NUM_CH-1:0][DATA_W-1:0] cnt_all;
   logic [NUM_CH-1:0][DATA_W-1:0] addr_all;
   logic [NUM_CH-1:0]             nmi_q;

   // request evaluation on the selected channel
   logic             req_err;
   logic [LEN_W-1:0] gnt_len;

   dmacc_eval #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eval (
      .mode    (mode_all[req_ch]),
      .cnt     (cnt_all[req_ch]),
      .req_len (req_len),
      .req_m2d (req_m2d),
      .err     (req_err),
      .gnt_len (gnt_len)
   );

   // channel register sets
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic sel_w;
         assign sel_w = csr_we && in_win && (csr_ch == CH_W'(i));
         dmacc_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_mode (sel_w && (csr_slot == 2'(SLOT_MODE))),
            .wr_cnt  (sel_w && (csr_slot == 2'(SLOT_CNT))),
            .wr_addr (sel_w && (csr_slot == 2'(SLOT_ADDR))),
            .wdata   (csr_wdata),
            .upd     (req_valid && (req_ch == CH_W'(i))),
            .upd_err (req_err),
            .upd_len (gnt_len),
            .mode_q  (mode_all[i]),
            .cnt_q   (cnt_all[i]),
            .addr_q  (addr_all[i])
         );
      end
   endgenerate

   // interrupt source word and response register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_len   <= '0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && req_err;
         rsp_len   <= (req_valid && !req_err) ? gnt_len : '0;
         rsp_addr  <= (req_valid && !req_err) ? addr_all[req_ch] : '0;
         if (req_valid && req_err) nmi_q[req_ch] <= 1'b1;
      end
   end

   dmacc_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdmux (
      .in_win   (in_win),
      .ch       (csr_ch),
      .slot     (csr_slot),
      .nmi_hit  (nmi_hit),
      .nmi      (nmi_q),
      .mode_all (mode_all),
      .cnt_all  (cnt_all),
      .addr_all (addr_all),
      .rdata    (csr_rdata)
   );
endmodule

// File: rtl/dmacc_checker.sv
module dmacc_checker #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_valid,
   input logic [CH_W-1:0]               req_ch,
   input logic [LEN_W-1:0]              req_len,
   input logic                          rsp_valid,
   input logic                          rsp_err,
   input logic [LEN_W-1:0]              rsp_len,
   input logic [DATA_W-1:0]             rsp_addr,
   input logic [NUM_CH-1:0]             nmi_q,
   input logic [NUM_CH-1:0][DATA_W-1:0] cnt_all
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_rsp_due_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      req_valid |=> rsp_valid);

   p_rsp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !req_valid |=> !rsp_valid);

   p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rsp_valid && rsp_err) |-> (rsp_len == '0 && rsp_addr == '0));

   p_err_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rsp_valid && rsp_err) |-> nmi_q[$past(req_ch)]);

   p_len_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rsp_valid && !rsp_err) |-> (rsp_len <= $past(req_len)));

   p_cnt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rsp_valid && !rsp_err) |->
         (cnt_all[$past(req_ch)] == $past(cnt_all[req_ch]) - DATA_W'(rsp_len)));

   p_nmi_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (nmi_q & $past(nmi_q)) == $past(nmi_q));
endmodule

bind dma_chan_ctrl dmacc_checker #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ch    (req_ch),
   .req_len   (req_len),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_len   (rsp_len),
   .rsp_addr  (rsp_addr),
   .nmi_q     (nmi_q),
   .cnt_all   (cnt_all)
);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;
   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [9:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ch = '0;
   logic [15:0] req_len = '0;
   logic        req_m2d = 1'b0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [15:0] rsp_len;
   logic [31:0] rsp_addr;

   always #(CLK_P/2) clk = ~clk;

   dma_chan_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
      .req_ch(req_ch), .req_len(req_len), .req_m2d(req_m2d),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len),
      .rsp_addr(rsp_addr)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct packed {
      logic        err;
      logic [15:0] len;
      logic [31:0] addr;
      logic [31:0] due;
   } exp_t;
   exp_t sb[$];

   // reference model built from the requirements
   logic [31:0] m_mode [4];
   logic [31:0] m_cnt  [4];
   logic [31:0] m_addr [4];
   logic [3:0]  m_nmi;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < 4; i++) begin
         m_mode[i] = '0; m_cnt[i] = '0; m_addr[i] = '0;
      end
      m_nmi = '0;
   endfunction

   function automatic logic [31:0] model_rd(input logic [9:0] a);
      int ch, slot;
      if (a >= 10'h100 && a < 10'h180) begin
         ch = (int'(a) - 'h100) >> 5;
         slot = (int'(a) >> 3) & 3;
         case (slot)
            1: return m_mode[ch];
            2: return m_cnt[ch];
            3: return m_addr[ch];
            default: return '0;
         endcase
      end
      if (a[9:2] == 8'h80) return {28'h0, m_nmi};
      return '0;
   endfunction

   // busy_ch: channel receiving a request in the same cycle, or -1
   function automatic void model_wr(input logic [9:0] a, input logic [31:0] d,
                                    input int busy_ch);
      int ch, slot;
      if (a >= 10'h100 && a < 10'h180) begin
         ch = (int'(a) - 'h100) >> 5;
         slot = (int'(a) >> 3) & 3;
         if (slot == 1 && ch != busy_ch) m_mode[ch] = d;
         if (slot == 2 && ch != busy_ch) m_cnt[ch] = d;
         if (slot == 3) m_addr[ch] = d;
      end
   endfunction

   function automatic exp_t model_req(input int ch, input logic [15:0] len,
                                      input bit m2d);
      exp_t e;
      logic bad;
      bad = !m_mode[ch][0] || (m2d != m_mode[ch][1]);
      e.due = 32'(cyc + 1);
      m_mode[ch][8]  = 1'b0;
      m_mode[ch][9]  = 1'b0;
      m_mode[ch][10] = 1'b0;
      if (bad) begin
         e.err = 1'b1; e.len = '0; e.addr = '0;
         m_mode[ch][9] = 1'b1;
         m_nmi[ch] = 1'b1;
      end else begin
         e.err = 1'b0;
         e.len = (m_cnt[ch] < 32'(len)) ? m_cnt[ch][15:0] : len;
         e.addr = m_addr[ch];
         m_cnt[ch] = m_cnt[ch] - 32'(e.len);
         m_mode[ch][8] = 1'b1;
      end
      return e;
   endfunction

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      model_wr(a, d, -1);
      @(posedge clk); #1;
      csr_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [9:0] a, input string tag);
      logic [31:0] e;
      @(negedge clk);
      csr_addr = a;
      #2;
      e = model_rd(a);
      check(csr_rdata === e, tag, csr_rdata, e);
   endtask

   task automatic req(input int ch, input logic [15:0] len, input bit m2d);
      @(negedge clk);
      req_valid = 1'b1; req_ch = 2'(ch); req_len = len; req_m2d = m2d;
      sb.push_back(model_req(ch, len, m2d));
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   // request and register write launched on the same edge
   task automatic req_wr(input int ch, input logic [15:0] len, input bit m2d,
                         input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_ch = 2'(ch); req_len = len; req_m2d = m2d;
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      sb.push_back(model_req(ch, len, m2d));
      model_wr(a, d, ch);
      @(posedge clk); #1;
      req_valid = 1'b0; csr_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R4 unexpected response", 32'(rsp_len), 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(32'(cyc) == e.due, "R4 response cycle", 32'(cyc), e.due);
            check(rsp_err == e.err, "R5 rsp_err", 32'(rsp_err), 32'(e.err));
            check(rsp_len == e.len, "R6 rsp_len", 32'(rsp_len), 32'(e.len));
            check(rsp_addr == e.addr, "R8 rsp_addr", rsp_addr, e.addr);
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(10'h108, "R1 ch0 mode");
      rd_chk(10'h170, "R1 ch3 count");
      rd_chk(10'h200, "R1 nmi word");
      check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);

      // R2 programming and readback
      wr(10'h108, 32'h0000_0001);
      wr(10'h110, 32'd100);
      wr(10'h118, 32'h0000_1000);
      wr(10'h100, 32'hdead_beef);
      rd_chk(10'h108, "R2 ch0 mode readback");
      rd_chk(10'h110, "R2 ch0 count readback");
      rd_chk(10'h118, "R2 ch0 addr readback");
      rd_chk(10'h100, "R2 slot0 reads zero");

      // R6 R8 accepted transfers with clamp
      req(0, 16'd40, 1'b0);
      rd_chk(10'h110, "R6 count after 40");
      rd_chk(10'h108, "R6 terminal count flag");
      rd_chk(10'h118, "R8 address unchanged");
      req(0, 16'd80, 1'b0);
      rd_chk(10'h110, "R6 count after clamp");
      req(0, 16'd5, 1'b0);
      rd_chk(10'h110, "R6 zero count grant");

      // R5 R7 direction mismatch and disabled channel
      req(0, 16'd5, 1'b1);
      rd_chk(10'h108, "R7 flags after refusal");
      rd_chk(10'h200, "R5 nmi bit 0");
      rd_chk(10'h110, "R5 count unchanged");
      req(1, 16'd8, 1'b0);
      rd_chk(10'h200, "R5 nmi bit 1");
      rd_chk(10'h128, "R5 ch1 memory error flag");

      // R7 preset flags cleared by an accepted request
      wr(10'h148, 32'h0000_0703);
      wr(10'h150, 32'd10);
      wr(10'h158, 32'h0000_2000);
      req(2, 16'd4, 1'b1);
      rd_chk(10'h148, "R7 ch2 flags cleared");
      rd_chk(10'h150, "R6 ch2 count");

      // R3 read-only nmi word and unmapped offsets
      wr(10'h200, 32'h0);
      rd_chk(10'h200, "R3 nmi write ignored");
      rd_chk(10'h180, "R3 offset 0x180 zero");
      rd_chk(10'h000, "R3 offset 0x000 zero");

      // R4 back-to-back requests
      wr(10'h168, 32'h0000_0001);
      wr(10'h170, 32'h0000_0020);
      wr(10'h178, 32'h0000_3000);
      req(3, 16'd8, 1'b0);
      req(3, 16'd8, 1'b0);
      req(3, 16'd30, 1'b0);
      rd_chk(10'h170, "R4 ch3 count after burst");

      // R9 sticky interrupt source after a good request
      req(0, 16'd3, 1'b0);
      rd_chk(10'h200, "R9 nmi still set");
      rd_chk(10'h108, "R7 ch0 error flag cleared");

      // R10 same-cycle write and request
      req_wr(2, 16'd2, 1'b1, 10'h150, 32'd99);
      rd_chk(10'h150, "R10 count write dropped");
      req_wr(2, 16'd2, 1'b1, 10'h158, 32'h0000_2400);
      rd_chk(10'h158, "R10 address write applied");
      req_wr(2, 16'd1, 1'b1, 10'h148, 32'h0);
      rd_chk(10'h148, "R10 mode write dropped");
      rd_chk(10'h150, "R10 count after requests");

      repeat (2) @(negedge clk);
      check(sb.size() == 0, "R4 all responses seen", 32'(sb.size()), 32'h0);

      // R1 second reset
      do_reset();
      rd_chk(10'h200, "R1 nmi cleared by reset");
      rd_chk(10'h110, "R1 count cleared by reset");
      rd_chk(10'h158, "R1 address cleared by reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule